// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block retunes a PLL when a new output rate is requested. A requester offers a target rate in hertz over a valid/ready handshake. The sequencer looks the rate up in a fixed table of supported settings. If the rate is missing from the table, the sequencer rejects the request and never touches the PLL. If the rate is found, the sequencer builds a control word from the table's divider and band codes and strobes the word into the PLL. It then waits a fixed relock interval, samples the lock and error status, and reports the outcome as a one-cycle response carrying a two-bit code.

The sequencer also drives the select of a companion interface-clock divider, and orders that update around a 500 MHz threshold so the interface clock never runs too fast:
- If the target is above the threshold, the divider is switched to /2 before the control word is issued.
- If the target is at or below the threshold, the divider returns to /1 only once a relock has completed cleanly.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `ifdiv_sel` is 0 (divide-by-1), and both `rsp_valid` and `pll_ctrl_we` are 0.
- R2: A rate that matches no table entry produces a response with code 2 (invalid). There is no write strobe, `pll_ctrl` is unchanged and `ifdiv_sel` is unchanged.
- R3: The written control word has power-down (bit 0) and bypass (bit 1) cleared. It places the output divider code at bits 3:2, the input divider code at bits 8:4, the feedback divider code at bits 15:9 and the band code from bit 20 upward. The table includes 100 MHz→(0,11,3), 500 MHz→(0,14,1), 1 GHz→(1,29,0) and 1.6 GHz→(1,47,0), listed as (input, feedback, output) codes.
- R4: For every accepted rate, the written word yields ref·2·(fb+1)/((in+1)·2^out) within 1 % of the requested rate, where ref is 33.333333 MHz.
- R5: The response appears exactly LOCK_WAIT+1 cycles after the cycle in which `pll_ctrl_we` is high. Lock and error are sampled in the cycle before the response.
- R6: If lock is low at the sample point, the response code is 1 (timeout).
- R7: If lock is high and error is high at the sample point, the response code is 2 (invalid).
- R8: If lock is high and error is low at the sample point, the response code is 0 (ok).
- R9: For a target above THRESH_HZ, `ifdiv_sel` is 1 (divide-by-2) no later than the write-strobe cycle, and it stays 1 whatever the outcome.
- R10: For a target at or below THRESH_HZ, `ifdiv_sel` goes to 0 only together with an ok response. On a failed outcome it is left unchanged.
- R11: `req_ready` is 0 from the cycle after acceptance until the sequence ends, and `rsp_valid` lasts exactly one cycle.
- R12: Each accepted table rate produces exactly one single-cycle `pll_ctrl_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_rate | input | RATE_W | Requested rate in Hz |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 ok, 1 timeout, 2 invalid |
| pll_ctrl | output | CTRL_W | PLL control word |
| pll_ctrl_we | output | 1 | Control word write strobe |
| pll_lock | input | 1 | PLL status: locked |
| pll_err | input | 1 | PLL status: error |
| ifdiv_sel | output | 1 | Interface divider select, 0 = /1, 1 = /2 |

## Verification
The bench builds the sequencer with LOCK_WAIT set to 20 cycles instead of the full 100 µs count. With that setting, every outcome, including relock timeouts, resolves within a few dozen cycles, so many back-to-back retunes fit in one run. The bench keeps THRESH_HZ at 500 MHz. This lets the sequences cross the threshold in both directions, including the exact 500 MHz boundary. Each crossing is combined with PLL-model modes for a clean lock, an error and no lock at all.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int RATE_W    = 32,
  parameter int CTRL_W    = 32,
  parameter int BAND_W    = 4,
  parameter int LOCK_WAIT = 10000,
  parameter longint THRESH_HZ = 500000000,
  parameter logic [CTRL_W-1:0] CTRL_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_rate,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [CTRL_W-1:0] pll_ctrl,
  output logic              pll_ctrl_we,
  input  logic              pll_lock,
  input  logic              pll_err,
  output logic              ifdiv_sel
);

  localparam int NENT  = 19;
  localparam int CNT_W = $clog2(LOCK_WAIT + 1);
  localparam int IDX_W = $clog2(NENT);
  localparam logic [1:0] C_OK = 2'd0, C_TMO = 2'd1, C_BAD = 2'd2;

  localparam logic [RATE_W-1:0] T_RATE [NENT] = '{
    100000000, 133000000, 200000000, 233000000, 300000000, 333000000,
    400000000, 500000000, 600000000, 700000000, 800000000, 900000000,
    1000000000, 1100000000, 1200000000, 1300000000, 1400000000,
    1500000000, 1600000000};
  localparam logic [4:0] T_IN [NENT] = '{
    0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam logic [6:0] T_FB [NENT] = '{
    11, 15, 47, 27, 35, 39, 47, 14, 17, 20, 23, 26, 29, 32, 35, 38, 41, 44, 47};
  localparam logic [1:0] T_OUT [NENT] = '{
    3, 3, 3, 2, 2, 2, 2, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [BAND_W-1:0] T_BAND [NENT] = '{default: '0};

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT, S_EVAL} st_t;
  st_t st;

  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [CTRL_W-1:0] word;
  logic              above;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NENT; i++)
      if (!hit && rate_q == T_RATE[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
  end

  always_comb begin
    word = '0;
    word[3:2]  = T_OUT[idx];
    word[8:4]  = T_IN[idx];
    word[15:9] = T_FB[idx];
    word[20 +: BAND_W] = T_BAND[idx];
  end

  assign above     = longint'(rate_q) > THRESH_HZ;
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rate_q      <= '0;
      cnt         <= '0;
      rsp_valid   <= 1'b0;
      rsp_code    <= C_OK;
      pll_ctrl    <= CTRL_RST;
      pll_ctrl_we <= 1'b0;
      ifdiv_sel   <= 1'b0;
    end else begin
      rsp_valid   <= 1'b0;
      pll_ctrl_we <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          rate_q <= req_rate;
          st     <= S_LOOK;
        end
        S_LOOK: if (!hit) begin
          rsp_valid <= 1'b1;
          rsp_code  <= C_BAD;
          st        <= S_IDLE;
        end else begin
          if (above) ifdiv_sel <= 1'b1;
          pll_ctrl    <= word;
          pll_ctrl_we <= 1'b1;
          cnt         <= '0;
          st          <= S_WAIT;
        end
        S_WAIT: if (cnt == CNT_W'(LOCK_WAIT - 1)) st <= S_EVAL;
                else cnt <= cnt + 1'b1;
        S_EVAL: begin
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
          if (!pll_lock)    rsp_code <= C_TMO;
          else if (pll_err) rsp_code <= C_BAD;
          else begin
            rsp_code <= C_OK;
            if (!above) ifdiv_sel <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int RATE_W = 32,
  parameter int CTRL_W = 32,
  parameter longint THRESH_HZ = 500000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [RATE_W-1:0] rate_q,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [CTRL_W-1:0] pll_ctrl,
  input logic              pll_ctrl_we,
  input logic              ifdiv_sel
);

  a_r3_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ctrl_we |-> pll_ctrl[1:0] == 2'b00);

  a_r9_div2_at_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_ctrl_we && longint'(rate_q) > THRESH_HZ) |-> ifdiv_sel);

  a_r9_rise_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifdiv_sel) |-> pll_ctrl_we);

  a_r10_fall_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ifdiv_sel) |-> (rsp_valid && rsp_code == 2'd0));

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r12_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ctrl_we |=> !pll_ctrl_we);

endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .RATE_W(RATE_W), .CTRL_W(CTRL_W), .THRESH_HZ(THRESH_HZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rate_q(rate_q), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .pll_ctrl(pll_ctrl), .pll_ctrl_we(pll_ctrl_we), .ifdiv_sel(ifdiv_sel)
);

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
  localparam int LW = 20;
  localparam longint REF = 33333333;
  localparam int NV = 12;
  // {rate, mode (0 lock,1 never,2 err), known}
  localparam logic [34:0] VEC [NV] = '{
    {32'd100000000, 2'd0, 1'b1},
    {32'd1600000000, 2'd0, 1'b1},
    {32'd500000000, 2'd1, 1'b1},
    {32'd500000000, 2'd2, 1'b1},
    {32'd500000000, 2'd0, 1'b1},
    {32'd1000000000, 2'd1, 1'b1},
    {32'd133000000, 2'd0, 1'b1},
    {32'd123456789, 2'd0, 1'b0},
    {32'd600000000, 2'd2, 1'b1},
    {32'd0, 2'd0, 1'b0},
    {32'd1000000000, 2'd0, 1'b1},
    {32'd400000000, 2'd0, 1'b1}};

  logic clk = 0, rst_n = 0, req_valid = 0, req_ready;
  logic [31:0] req_rate = 0, pll_ctrl;
  logic rsp_valid, pll_ctrl_we, pll_lock, pll_err, ifdiv_sel;
  logic [1:0] rsp_code;
  logic [1:0] mode = 0;
  int mcnt = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pll_retune_seq #(.LOCK_WAIT(LW)) u_pll_retune_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .pll_ctrl(pll_ctrl), .pll_ctrl_we(pll_ctrl_we), .pll_lock(pll_lock),
    .pll_err(pll_err), .ifdiv_sel(ifdiv_sel));

  always @(posedge clk)
    if (pll_ctrl_we) mcnt <= 0;
    else if (mcnt < 1000) mcnt <= mcnt + 1;
  assign pll_lock = (mode != 2'd1) && mcnt >= 5;
  assign pll_err  = (mode == 2'd2) && pll_lock;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] rate, input logic [1:0] md, input bit known,
                     inout logic exp_div);
    logic [31:0] prev_ctrl;
    int kw, kr, nw;
    logic [31:0] w;
    logic dw;
    logic [1:0] ecode;
    longint f;
    mode = md;
    prev_ctrl = pll_ctrl;
    @(negedge clk);
    req_valid = 1; req_rate = rate;
    @(negedge clk);
    req_rate = 32'd777;  // held off while busy
    chk(req_ready == 0, "R11 busy ready", req_ready, 0);
    kw = -1; kr = -1; nw = 0; w = 0; dw = 0;
    for (int k = 1; k < 200 && kr < 0; k++) begin
      if (pll_ctrl_we) begin nw++; kw = k; w = pll_ctrl; dw = ifdiv_sel; end
      if (rsp_valid) kr = k;
      else @(negedge clk);
    end
    req_valid = 0;
    ecode = !known ? 2'd2 : md == 2'd1 ? 2'd1 : md == 2'd2 ? 2'd2 : 2'd0;
    if (known && rate > 500000000) exp_div = 1;
    else if (known && ecode == 0) exp_div = 0;
    chk(kr > 0, "R11 response seen", kr, 1);
    chk(rsp_code == ecode, known ? (md == 1 ? "R6 timeout" : md == 2 ? "R7 err" : "R8 ok") : "R2 unknown",
        rsp_code, ecode);
    chk(ifdiv_sel == exp_div, rate > 500000000 ? "R9 div select" : "R10 div select",
        ifdiv_sel, exp_div);
    chk(nw == (known ? 1 : 0), "R12 write count", nw, known ? 1 : 0);
    if (!known) chk(pll_ctrl == prev_ctrl, "R2 ctrl untouched", pll_ctrl, prev_ctrl);
    else begin
      chk(kr - kw == LW + 1, "R5 relock wait", kr - kw, LW + 1);
      chk(w[1:0] == 0, "R3 pd/bypass clear", w[1:0], 0);
      f = REF * 2 * (w[15:9] + 1) / ((w[8:4] + 1) << w[3:2]);
      chk((f > rate ? f - rate : rate - f) * 100 < rate, "R4 frequency", f, rate);
      if (rate > 500000000) chk(dw == 1, "R9 div2 at write", dw, 1);
      case (rate)
        100000000:  chk(w[15:2] == {7'd11, 5'd0, 2'd3}, "R3 codes 100M", w[15:2], {7'd11, 5'd0, 2'd3});
        500000000:  chk(w[15:2] == {7'd14, 5'd0, 2'd1}, "R3 codes 500M", w[15:2], {7'd14, 5'd0, 2'd1});
        1000000000: chk(w[15:2] == {7'd29, 5'd1, 2'd0}, "R3 codes 1G", w[15:2], {7'd29, 5'd1, 2'd0});
        1600000000: chk(w[15:2] == {7'd47, 5'd1, 2'd0}, "R3 codes 1.6G", w[15:2], {7'd47, 5'd1, 2'd0});
        default: ;
      endcase
    end
    @(negedge clk);
    chk(rsp_valid == 0, "R11 one-cycle rsp", rsp_valid, 0);
  endtask

  initial begin
    logic ediv;
    ediv = 0;
    #1;
    chk(req_ready == 1 && ifdiv_sel == 0, "R1 reset state", {req_ready, ifdiv_sel}, 2'b10);
    chk(rsp_valid == 0 && pll_ctrl_we == 0, "R1 reset outputs", {rsp_valid, pll_ctrl_we}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && ifdiv_sel == 0, "R1 after release", {req_ready, ifdiv_sel}, 2'b10);
    for (int i = 0; i < NV; i++)
      run(VEC[i][34:3], VEC[i][2:1], VEC[i][0], ediv);
    // corner: from /2 state, unknown rate must leave divider at /2
    run(32'd1600000000, 2'd0, 1'b1, ediv);
    run(32'd500000001, 2'd0, 1'b0, ediv);
    // corner: at-threshold timeout leaves /2, then clean relock releases it
    run(32'd500000000, 2'd1, 1'b1, ediv);
    run(32'd500000000, 2'd0, 1'b1, ediv);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule